// File: doc/BRIEF.md
# Dual-Clock FIFO with Almost-Full and Almost-Empty Flags

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. Words enter on the write clock and leave on the read clock, held meanwhile in a small two-port storage array. Each side qualifies its operation with two enables: a clock enable and an operation enable. Each side also reports its own status flags, registered in its own clock domain. The write side raises full and almost-full. The read side raises empty and almost-empty.

Each side keeps a binary pointer one bit wider than the array address. The pointer is copied into Gray code and passed to the other domain through a two-stage synchroniser. There it is turned back into binary and subtracted from the local pointer to give an occupancy figure. That figure drives both flags of the domain. The figure seen across the crossing is always stale in the safe direction, so full and empty may clear late but never early. The two almost thresholds are parameters. Depth is a power of two set by the address width.

Top module: `dcfifo_almost`

## Requirements
- R1: After reset of both domains, empty and aempty are 1, full and afull are 0, and rdata is all zeros.
- R2: A word is stored at a write-clock edge only when wce and wen are both 1 and full is 0. Otherwise nothing is stored and the write pointer does not move.
- R3: Words come out of rdata in the order in which they were accepted, across several data patterns and across pointer wrap-around.
- R4: full becomes 1 once 2**ADDR_W words (16 by default) are held. Writes attempted while full is 1 are dropped and do not appear in the later read-out.
- R5: A read attempted while empty is 1 is not accepted, and rdata keeps its previous value.
- R6: afull is 1 exactly when the occupancy seen by the write domain is at or above AF_LEVEL (12 by default).
- R7: aempty is 1 exactly when the occupancy seen by the read domain is at or below AE_LEVEL (3 by default).
- R8: rdata is a register on rclk. It takes the oldest word at the read-clock edge that accepts a read, and otherwise holds its value.
- R9: A word is removed at a read-clock edge only when rce and ren are both 1 and empty is 0.
- R10: Each domain's synchronous active-low reset clears that domain's pointer and returns its flags to the reset values of R1. The FIFO then works normally again.
- R11: empty stays 1 for at least the first read-clock edge after the write that fills an empty FIFO. full stays 1 for at least the first write-clock edge after the read that drains a full FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain synchronous reset, active low |
| wce | input | 1 | Write clock enable |
| wen | input | 1 | Write enable |
| wdata | input | DATA_W | Word to store |
| full | output | 1 | No free location (write domain) |
| afull | output | 1 | Occupancy at or above AF_LEVEL (write domain) |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain synchronous reset, active low |
| rce | input | 1 | Read clock enable |
| ren | input | 1 | Read enable |
| rdata | output | DATA_W | Registered oldest word |
| empty | output | 1 | No stored word (read domain) |
| aempty | output | 1 | Occupancy at or below AE_LEVEL (read domain) |

## Verification
Ordering is tried with walking-one words, with alternating 0x155/0x0AA words and with an ascending run that fills the array and wraps the pointers. This separates a wrong address from a stuck or swapped data bit. Enable patterns with only one of the two enables high show whether each side's gate requires both enables. Writes against a full array and reads against an empty one show whether the flags really block the pointer. The occupancy is stepped one word either side of each threshold to catch an off-by-one in the almost flags. Sampling one edge after a fill or a drain shows whether the crossing reports a change too early.

// File: rtl/dcf_pkg.sv
// Package for the dual-clock FIFO.
// Holds the default geometry and thresholds that the top module and the bench share.
package dcf_pkg;
    localparam int unsigned DEF_DATA_W   = 9;
    localparam int unsigned DEF_ADDR_W   = 4;
    localparam int unsigned DEF_AF_LEVEL = 12;
    localparam int unsigned DEF_AE_LEVEL = 3;
    localparam int unsigned SYNC_STAGES  = 2;
endpackage

// File: rtl/dcf_ptr_sync.sv
// Carries a Gray-coded pointer into another clock domain through a flop chain.
// Hands back the pointer in binary.
// Assumes the source changes at most one bit per source clock (Gray code).
// The reset is synchronous to the destination clock and active low.
module dcf_ptr_sync #(
    parameter int unsigned PW     = 5,
    parameter int unsigned STAGES = dcf_pkg::SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] chain [STAGES];

    // Shift the foreign Gray pointer through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= gray_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    // Turn the settled Gray value into binary, top bit first.
    always_comb begin
        bin_out[PW-1] = chain[STAGES-1][PW-1];
        for (int b = PW - 2; b >= 0; b--) begin
            bin_out[b] = bin_out[b+1] ^ chain[STAGES-1][b];
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-domain control: the write pointer, its Gray copy, and the full and almost-full flags.
// The flags are registered from the next-state pointer, so they are current on the same edge as the write.
// Assumes rbin_s is the read pointer already brought into this domain.
module dcf_wr_ctrl #(
    parameter int unsigned AW       = 4,
    parameter int unsigned AF_LEVEL = 12
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wce,
    input  logic          wen,
    input  logic [AW:0]   rbin_s,
    output logic          wacc,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          afull
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [PW-1:0] OCC_FULL = PW'(DEPTH);
    localparam logic [PW-1:0] OCC_AF   = PW'(AF_LEVEL);

    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] occ_nxt;

    // Accept a write only when both enables are high and there is room.
    always_comb begin
        wacc     = wce & wen & ~full;
        waddr    = wbin[AW-1:0];
        wbin_nxt = wbin + PW'(wacc);
        occ_nxt  = wbin_nxt - rbin_s;
    end

    // Advance the pointer and register the write-domain flags.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
            afull <= 1'b0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
            full  <= (occ_nxt == OCC_FULL);
            afull <= (occ_nxt >= OCC_AF);
        end
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-domain control: the read pointer, its Gray copy, and the empty and almost-empty flags.
// The flags are registered from the next-state pointer.
// Assumes wbin_s is the write pointer already brought into this domain.
module dcf_rd_ctrl #(
    parameter int unsigned AW       = 4,
    parameter int unsigned AE_LEVEL = 3
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rce,
    input  logic          ren,
    input  logic [AW:0]   wbin_s,
    output logic          racc,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          aempty
);
    localparam int unsigned PW = AW + 1;
    localparam logic [PW-1:0] OCC_AE = PW'(AE_LEVEL);

    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] occ_nxt;

    // Accept a read only when both enables are high and a word is held.
    always_comb begin
        racc     = rce & ren & ~empty;
        raddr    = rbin[AW-1:0];
        rbin_nxt = rbin + PW'(racc);
        occ_nxt  = wbin_s - rbin_nxt;
    end

    // Advance the pointer and register the read-domain flags.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            empty  <= 1'b1;
            aempty <= 1'b1;
        end else begin
            rbin   <= rbin_nxt;
            rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
            empty  <= (occ_nxt == '0);
            aempty <= (occ_nxt <= OCC_AE);
        end
    end
endmodule

// File: rtl/dcf_store.sv
// Two-port storage: one write port on wclk and one registered read port on rclk.
// The array has no reset. The output register is cleared by the read-domain reset.
// Assumes the controls never let a write and a read reach the same live location.
module dcf_store #(
    parameter int unsigned DW = 9,
    parameter int unsigned AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store the accepted word.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Load the output register on an accepted read, hold it otherwise.
    always_ff @(posedge rclk) begin
        if (!rrst_n)  rdata <= '0;
        else if (re)  rdata <= cells[raddr];
    end
endmodule

// File: rtl/dcfifo_almost.sv
// Top of the dual-clock FIFO.
// Joins the write control, the read control, the two pointer crossings and the storage.
// Assumes AF_LEVEL <= 2**ADDR_W, AE_LEVEL < 2**ADDR_W, and that each reset is synchronous to its own clock.
module dcfifo_almost #(
    parameter int unsigned DATA_W   = dcf_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W   = dcf_pkg::DEF_ADDR_W,
    parameter int unsigned AF_LEVEL = dcf_pkg::DEF_AF_LEVEL,
    parameter int unsigned AE_LEVEL = dcf_pkg::DEF_AE_LEVEL
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wce,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    output logic              full,
    output logic              afull,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rce,
    input  logic              ren,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              aempty
);
    localparam int unsigned PW = ADDR_W + 1;

    logic              wacc, racc;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0]     w_bin_in_rd, r_bin_in_wr;

    dcf_wr_ctrl #(.AW(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .wce(wce), .wen(wen),
        .rbin_s(r_bin_in_wr), .wacc(wacc), .waddr(waddr),
        .wbin(w_bin), .wgray(w_gray), .full(full), .afull(afull)
    );

    dcf_rd_ctrl #(.AW(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .rce(rce), .ren(ren),
        .wbin_s(w_bin_in_rd), .racc(racc), .raddr(raddr),
        .rbin(r_bin), .rgray(r_gray), .empty(empty), .aempty(aempty)
    );

    dcf_ptr_sync #(.PW(PW)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .gray_in(w_gray), .bin_out(w_bin_in_rd)
    );

    dcf_ptr_sync #(.PW(PW)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .gray_in(r_gray), .bin_out(r_bin_in_wr)
    );

    dcf_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wclk), .we(wacc), .waddr(waddr), .wdata(wdata),
        .rclk(rclk), .rrst_n(rrst_n), .re(racc), .raddr(raddr), .rdata(rdata)
    );
endmodule

// File: rtl/dcf_checker.sv
// Property checker for dcfifo_almost, attached by bind.
// Watches the flag ports and the two internal pointers.
// Each domain's properties are clocked and disabled by that domain's own reset.
module dcf_checker #(
    parameter int unsigned DW = 9,
    parameter int unsigned PW = 5
) (
    input logic          wclk,
    input logic          wrst_n,
    input logic          wce,
    input logic          wen,
    input logic          full,
    input logic          afull,
    input logic          rclk,
    input logic          rrst_n,
    input logic          rce,
    input logic          ren,
    input logic          empty,
    input logic          aempty,
    input logic [DW-1:0] rdata,
    input logic [PW-1:0] w_bin,
    input logic [PW-1:0] r_bin
);
    p_no_overflow_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
        full |=> (w_bin == $past(w_bin)));

    p_write_gate_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
        !(wce && wen) |=> (w_bin == $past(w_bin)));

    p_full_has_afull_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
        full |-> afull);

    p_no_underflow_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
        empty |=> (r_bin == $past(r_bin)));

    p_read_gate_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
        !(rce && ren) |=> (r_bin == $past(r_bin)));

    p_empty_has_aempty_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
        empty |-> aempty);

    p_rdata_hold_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
        !(rce && ren && !empty) |=> $stable(rdata));
endmodule

bind dcfifo_almost dcf_checker #(.DW(DATA_W), .PW(ADDR_W + 1)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .wce(wce), .wen(wen),
    .full(full), .afull(afull),
    .rclk(rclk), .rrst_n(rrst_n), .rce(rce), .ren(ren),
    .empty(empty), .aempty(aempty), .rdata(rdata),
    .w_bin(w_bin), .r_bin(r_bin)
);

// File: tb/sim_dcfifo_almost.sv
// Directed bench for dcfifo_almost.
// The write clock runs at 250 MHz and the read clock runs slower, on its own phase.
module sim_dcfifo_almost;
    localparam int DW    = 9;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int AFL   = 12;
    localparam int AEL   = 3;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst_n = 1'b0, rrst_n = 1'b0;
    logic          wce = 1'b0, wen = 1'b0, rce = 1'b0, ren = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          full, afull, empty, aempty;

    int n_chk = 0;
    int n_bad = 0;

    dcfifo_almost #(.DATA_W(DW), .ADDR_W(AW), .AF_LEVEL(AFL), .AE_LEVEL(AEL)) u0 (
        .wclk(wclk), .wrst_n(wrst_n), .wce(wce), .wen(wen), .wdata(wdata),
        .full(full), .afull(afull),
        .rclk(rclk), .rrst_n(rrst_n), .rce(rce), .ren(ren), .rdata(rdata),
        .empty(empty), .aempty(aempty)
    );

    always #2 wclk = ~wclk;
    initial begin
        #1.3;
        forever #3 rclk = ~rclk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] v, input bit ce = 1'b1, input bit en = 1'b1);
        @(negedge wclk);
        wce = ce; wen = en; wdata = v;
        @(negedge wclk);
        wce = 1'b0; wen = 1'b0;
    endtask

    task automatic pop(output logic [DW-1:0] v, input bit ce = 1'b1, input bit en = 1'b1);
        @(negedge rclk);
        rce = ce; ren = en;
        @(negedge rclk);
        rce = 1'b0; ren = 1'b0;
        v = rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge rclk);
        repeat (5) @(negedge wclk);
    endtask

    task automatic apply_reset();
        wrst_n = 1'b0; rrst_n = 1'b0;
        repeat (4) @(negedge rclk);
        wrst_n = 1'b1; rrst_n = 1'b1;
        settle();
    endtask

    // R1: flags and output after reset.
    task automatic t_reset();
        apply_reset();
        check(empty  == 1'b1, "R1", "empty",  empty,  1);
        check(aempty == 1'b1, "R1", "aempty", aempty, 1);
        check(full   == 1'b0, "R1", "full",   full,   0);
        check(afull  == 1'b0, "R1", "afull",  afull,  0);
        check(rdata  == '0,   "R1", "rdata",  rdata,  0);
    endtask

    // R2, R9, R8, R11: each side needs both enables; the crossing is not early.
    task automatic t_gating();
        logic [DW-1:0] v;
        push(9'h011, 1'b1, 1'b0);
        push(9'h022, 1'b0, 1'b1);
        settle();
        check(empty == 1'b1, "R2", "empty after gated writes", empty, 1);
        push(9'h0C3);
        @(negedge rclk);
        check(empty == 1'b1, "R11", "empty one read edge after write", empty, 1);
        settle();
        check(empty == 1'b0, "R2", "empty after real write", empty, 0);
        pop(v, 1'b0, 1'b1);
        check(v == 9'h000, "R9", "rdata with rce low", v, 0);
        pop(v, 1'b1, 1'b0);
        check(v == 9'h000, "R8", "rdata with ren low", v, 0);
        settle();
        check(empty == 1'b0, "R9", "word kept after gated reads", empty, 0);
        pop(v);
        check(v == 9'h0C3, "R3", "single word", v, 'h0C3);
        settle();
        check(empty == 1'b1, "R9", "empty after read", empty, 1);
    endtask

    // R3: ordering with walking-one and alternating patterns.
    task automatic t_order();
        logic [DW-1:0] v;
        for (int i = 0; i < DW; i++) push(DW'(1) << i);
        settle();
        for (int i = 0; i < DW; i++) begin
            pop(v);
            check(v == (DW'(1) << i), "R3", "walking one", v, 1 << i);
        end
        for (int i = 0; i < 6; i++) push((i % 2) ? 9'h0AA : 9'h155);
        settle();
        for (int i = 0; i < 6; i++) begin
            pop(v);
            check(v == ((i % 2) ? 9'h0AA : 9'h155), "R3", "alternating", v,
                  (i % 2) ? 'h0AA : 'h155);
        end
        settle();
    endtask

    // R4, R5, R11, R3: fill, push against full, drain, pop against empty.
    task automatic t_full();
        logic [DW-1:0] v;
        for (int i = 0; i < DEPTH; i++) push(DW'(100 + i));
        settle();
        check(full  == 1'b1, "R4", "full after DEPTH writes", full, 1);
        check(afull == 1'b1, "R6", "afull when full", afull, 1);
        for (int i = 0; i < 3; i++) push(9'h1AA);
        settle();
        pop(v);
        check(v == DW'(100), "R3", "first after wrap", v, 100);
        @(negedge wclk);
        check(full == 1'b1, "R11", "full one write edge after read", full, 1);
        settle();
        check(full == 1'b0, "R4", "full clears after read", full, 0);
        for (int i = 1; i < DEPTH; i++) begin
            pop(v);
            check(v == DW'(100 + i), "R4", "drain without dropped writes", v, 100 + i);
        end
        settle();
        check(empty == 1'b1, "R4", "extra writes were dropped", empty, 1);
        pop(v);
        check(v == DW'(100 + DEPTH - 1), "R5", "rdata held on empty read", v, 100 + DEPTH - 1);
    endtask

    // R6, R7: step either side of both thresholds.
    task automatic t_almost();
        logic [DW-1:0] v;
        for (int i = 0; i < AFL - 1; i++) push(DW'(200 + i));
        settle();
        check(afull == 1'b0, "R6", "afull below level", afull, 0);
        push(DW'(200 + AFL - 1));
        settle();
        check(afull == 1'b1, "R6", "afull at level", afull, 1);
        check(aempty == 1'b0, "R7", "aempty with many words", aempty, 0);
        for (int i = 0; i < AFL - AEL - 1; i++) pop(v);
        settle();
        check(aempty == 1'b0, "R7", "aempty one above level", aempty, 0);
        check(afull == 1'b0, "R6", "afull after drain", afull, 0);
        pop(v);
        settle();
        check(aempty == 1'b1, "R7", "aempty at level", aempty, 1);
        check(v == DW'(200 + AFL - AEL - 1), "R3", "order through thresholds", v, 200 + AFL - AEL - 1);
        for (int i = 0; i < AEL; i++) pop(v);
        settle();
        check(empty == 1'b1, "R7", "empty after last", empty, 1);
    endtask

    // R10: reset both domains with words held, then reuse.
    task automatic t_domain_reset();
        logic [DW-1:0] v;
        for (int i = 0; i < 5; i++) push(DW'(300 + i));
        settle();
        check(empty == 1'b0, "R10", "words held before reset", empty, 0);
        apply_reset();
        check(empty == 1'b1 && aempty == 1'b1, "R10", "read flags after reset", {empty, aempty}, 3);
        check(full == 1'b0 && afull == 1'b0, "R10", "write flags after reset", {full, afull}, 0);
        push(9'h07E);
        settle();
        pop(v);
        check(v == 9'h07E, "R10", "word after reset", v, 'h07E);
    endtask

    initial begin
        t_reset();
        t_gating();
        t_order();
        t_full();
        t_almost();
        t_domain_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule